// File: doc/BRIEF.md
# Sync-Header Block Lock Synchronizer

This block takes a serial bitstream, one bit per accepted cycle, whose block boundary is not known. It finds that boundary for blocks of 66 or 67 bits. The length is picked by a mode input. Each block opens with a two-bit sync header. A header is good when its two bits differ.

While it is hunting, the block checks the header at its current candidate boundary once per block. Each bad header moves the candidate one bit later: the bit that follows the bad block is thrown away. A run of good headers of a set length declares lock. Once locked, the block counts bad headers inside a fixed window of headers. If too many fall inside one window, lock is dropped and hunting starts again.

Every completed block is presented as a word. Each locked block that carries a bad header also raises a one-cycle error pulse.

Top module: `shdr_block_sync`

## Requirements
- R1: With `mode_i`=0 a block is 66 bits long; with `mode_i`=1 it is 67 bits long. A block is counted from the first bit accepted after reset, after a mode change or after a slip.
- R2: While unlocked, a block with a bad header causes exactly one bit to be discarded. The discarded bit is the next accepted bit, so the candidate boundary moves one bit later.
- R3: A header is good only when its two bits differ, that is 01 or 10. The header is formed from the first two bits received in a block. 00 and 11 are bad.
- R4: Lock (`block_lock`=1) rises in the same cycle as the word of the 64th consecutive good header. Any bad header while hunting clears the good-header count.
- R5: `hdr_err` pulses together with `word_valid` only for a bad-header block that arrives while `block_lock` was already 1. It never pulses while the block is unlocked.
- R6: While locked, the 16th bad header inside one window of 64 headers clears `block_lock` in the cycle of that word. It also causes a slip.
- R7: The window restarts at lock and after every 64 locked headers. Bad headers from a window that has finished do not count toward the limit of 16.
- R8: Reset, or a change of `mode_i`, clears lock, the bit alignment and all counters. After either one, lock needs a fresh 64 good headers.
- R9: After a slip, the next header is checked only after one full new block of bits has been received.
- R10: `word_o` holds the last completed block. The first bit received sits at bit L-1. In 66-bit mode bit 66 is 0. `word_valid` is high for the one cycle after the block's last bit is clocked in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | Block length select: 0 = 66 bits, 1 = 67 bits |
| in_valid | input | 1 | `in_bit` carries a stream bit this cycle |
| in_bit | input | 1 | Serial stream bit |
| word_valid | output | 1 | One-cycle strobe: a block completed |
| word_o | output | 67 | Last completed block, first bit received at the top |
| hdr_err | output | 1 | Bad header received while locked |
| block_lock | output | 1 | Block boundary locked |

## Verification
The bench builds the block with its default parameters: a lock run of 64 headers, a window of 64 headers, a loss limit of 16, and lengths of 66 and 67. Because these values are small, the exact lock cycle, the window restart and the 16th-error loss can all be reached with short directed streams in both modes.

Streams with random leading offsets, up to 40 bits, push the hunt through many slips in a row before lock. The bench then checks that every locked word is a whole, in-order block. Directed cases check the following:
- a single one-bit slip;
- the good-header count being cleared one block short of lock;
- lock being cleared by a mode change or by reset.

// File: rtl/shdr_sync_pkg.sv
package shdr_sync_pkg;

  // Hunt / locked state of the lock machine.
  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } lock_st_e;

  // A sync header is good when its two bits differ.
  function automatic logic hdr_is_good(input logic [1:0] hdr);
    return hdr[1] ^ hdr[0];
  endfunction

  // Block length chosen by the mode bit.
  function automatic int unsigned blk_len(input logic m_long,
                                          input int unsigned len_short,
                                          input int unsigned len_long);
    return m_long ? len_long : len_short;
  endfunction

endpackage

// File: rtl/shdr_framer.sv
module shdr_framer
  import shdr_sync_pkg::*;
#(
  parameter int LEN_A = 66,
  parameter int LEN_B = 67
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     clr,
  input  logic                                     in_valid,
  input  logic                                     in_bit,
  input  logic                                     m_long,
  input  logic                                     slip,
  output logic                                     blk_done,
  output logic [((LEN_A > LEN_B) ? LEN_A : LEN_B)-1:0] blk_word,
  output logic [1:0]                               blk_hdr,
  output logic                                     skip_pend
);
  localparam int W  = (LEN_A > LEN_B) ? LEN_A : LEN_B;
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  sr_q;
  logic [W-1:0]  nxt_sr;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_idx;
  logic [CW-1:0] hdr_lo;
  logic          skip_q;

  // Index of the last bit of the current block and of the header's low bit.
  assign last_idx  = CW'(blk_len(m_long, LEN_A, LEN_B) - 1);
  assign hdr_lo    = last_idx - CW'(1);
  assign nxt_sr    = {sr_q[W-2:0], in_bit};
  assign blk_done  = in_valid && !skip_q && (cnt_q == last_idx);
  assign skip_pend = skip_q;

  always_comb begin
    for (int i = 0; i < W; i++) begin
      blk_word[i] = (i <= int'(last_idx)) ? nxt_sr[i] : 1'b0;
    end
    blk_hdr = {nxt_sr[last_idx], nxt_sr[hdr_lo]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      skip_q <= 1'b0;
    end else if (clr) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      skip_q <= 1'b0;
    end else if (in_valid) begin
      if (skip_q) begin
        // This bit is discarded: the boundary moves one bit later.
        skip_q <= 1'b0;
      end else begin
        sr_q <= nxt_sr;
        if (blk_done) begin
          cnt_q  <= '0;
          skip_q <= slip;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/shdr_lock_fsm.sv
module shdr_lock_fsm
  import shdr_sync_pkg::*;
#(
  parameter int LOCK_GOOD = 64,
  parameter int WIN_HDRS  = 64,
  parameter int BAD_MAX   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic hdr_evt,
  input  logic hdr_good,
  output logic locked,
  output logic slip,
  output logic err_evt,
  output logic lock_gain,
  output logic lock_loss
);
  localparam int GW = $clog2(LOCK_GOOD + 1);
  localparam int WW = $clog2(WIN_HDRS + 1);
  localparam int BW = $clog2(BAD_MAX + 1);

  lock_st_e      st_q;
  logic [GW-1:0] good_q, good_n;
  logic [WW-1:0] win_q, win_n, win_t;
  logic [BW-1:0] bad_q, bad_n, bad_t;

  assign locked = (st_q == ST_LOCK);

  always_comb begin
    slip      = 1'b0;
    lock_gain = 1'b0;
    lock_loss = 1'b0;
    err_evt   = 1'b0;
    good_n    = good_q;
    win_n     = win_q;
    bad_n     = bad_q;
    win_t     = win_q + WW'(1);
    bad_t     = bad_q + {{(BW-1){1'b0}}, ~hdr_good};
    if (hdr_evt) begin
      if (st_q == ST_HUNT) begin
        if (hdr_good) begin
          if (good_q == GW'(LOCK_GOOD - 1)) begin
            lock_gain = 1'b1;
            good_n    = '0;
          end else begin
            good_n = good_q + GW'(1);
          end
        end else begin
          good_n = '0;
          slip   = 1'b1;
        end
      end else begin
        err_evt = ~hdr_good;
        if (bad_t == BW'(BAD_MAX)) begin
          lock_loss = 1'b1;
          slip      = 1'b1;
          bad_n     = '0;
          win_n     = '0;
        end else if (win_t == WW'(WIN_HDRS)) begin
          bad_n = '0;
          win_n = '0;
        end else begin
          bad_n = bad_t;
          win_n = win_t;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HUNT;
      good_q <= '0;
      win_q  <= '0;
      bad_q  <= '0;
    end else if (clr) begin
      st_q   <= ST_HUNT;
      good_q <= '0;
      win_q  <= '0;
      bad_q  <= '0;
    end else begin
      good_q <= good_n;
      win_q  <= win_n;
      bad_q  <= bad_n;
      if (lock_gain)      st_q <= ST_LOCK;
      else if (lock_loss) st_q <= ST_HUNT;
    end
  end

endmodule

// File: rtl/shdr_block_sync.sv
module shdr_block_sync
  import shdr_sync_pkg::*;
#(
  parameter int LEN_A     = 66,
  parameter int LEN_B     = 67,
  parameter int LOCK_GOOD = 64,
  parameter int WIN_HDRS  = 64,
  parameter int BAD_MAX   = 16
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     mode_i,
  input  logic                                     in_valid,
  input  logic                                     in_bit,
  output logic                                     word_valid,
  output logic [((LEN_A > LEN_B) ? LEN_A : LEN_B)-1:0] word_o,
  output logic                                     hdr_err,
  output logic                                     block_lock
);
  localparam int W = (LEN_A > LEN_B) ? LEN_A : LEN_B;

  logic         mode_q;
  logic         mode_chg;
  logic         blk_done;
  logic [W-1:0] blk_word;
  logic [1:0]   blk_hdr;
  logic         skip_pend;
  logic         slip;
  logic         err_evt;
  logic         lock_gain;
  logic         lock_loss;
  logic         hdr_good;

  // A mode change takes effect as a clear of the whole datapath.
  assign mode_chg = (mode_i != mode_q);
  assign hdr_good = hdr_is_good(blk_hdr);

  shdr_framer #(
    .LEN_A(LEN_A),
    .LEN_B(LEN_B)
  ) u_framer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (mode_chg),
    .in_valid (in_valid),
    .in_bit   (in_bit),
    .m_long   (mode_q),
    .slip     (slip),
    .blk_done (blk_done),
    .blk_word (blk_word),
    .blk_hdr  (blk_hdr),
    .skip_pend(skip_pend)
  );

  shdr_lock_fsm #(
    .LOCK_GOOD(LOCK_GOOD),
    .WIN_HDRS (WIN_HDRS),
    .BAD_MAX  (BAD_MAX)
  ) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (mode_chg),
    .hdr_evt  (blk_done),
    .hdr_good (hdr_good),
    .locked   (block_lock),
    .slip     (slip),
    .err_evt  (err_evt),
    .lock_gain(lock_gain),
    .lock_loss(lock_loss)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= 1'b0;
      word_valid <= 1'b0;
      word_o     <= '0;
      hdr_err    <= 1'b0;
    end else if (mode_chg) begin
      mode_q     <= mode_i;
      word_valid <= 1'b0;
      hdr_err    <= 1'b0;
    end else begin
      word_valid <= blk_done;
      hdr_err    <= err_evt;
      if (blk_done) word_o <= blk_word;
    end
  end

endmodule

// File: rtl/shdr_block_sync_chk.sv
module shdr_block_sync_chk #(
  parameter int W = 67
) (
  input logic         clk,
  input logic         rst_n,
  input logic         mode_q,
  input logic         mode_chg,
  input logic         slip,
  input logic         word_valid,
  input logic [W-1:0] word_o,
  input logic         hdr_err,
  input logic         block_lock
);
  logic [1:0] out_hdr;
  assign out_hdr = mode_q ? word_o[W-1:W-2] : word_o[W-2:W-3];

  // R5: an error pulse rides on a word and needs lock held before it
  p_err_on_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_err |-> word_valid);
  p_err_needs_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_err |-> $past(block_lock));

  // R4: lock rises only with a word that carries a good header
  p_gain_on_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(block_lock) |-> (word_valid && !hdr_err));

  // R3: a locked word without an error pulse has a header of differing bits
  p_hdr_good_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !hdr_err && $past(block_lock)) |-> (out_hdr[1] != out_hdr[0]));

  // R6: lock falls with an error pulse unless a mode change cleared it
  p_loss_on_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(block_lock) && !$past(mode_chg)) |-> hdr_err);

  // R2: a slip leaves the block unlocked
  p_slip_unlocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    slip |=> !block_lock);

  // R8: a mode change clears lock and the word strobe
  p_mode_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (!block_lock && !word_valid));

endmodule

bind shdr_block_sync shdr_block_sync_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_q    (mode_q),
  .mode_chg  (mode_chg),
  .slip      (slip),
  .word_valid(word_valid),
  .word_o    (word_o),
  .hdr_err   (hdr_err),
  .block_lock(block_lock)
);

// File: tb/tb_shdr_block_sync.sv
`timescale 1ns/1ps
module tb_shdr_block_sync;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_i = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_bit = 1'b0;
  logic        word_valid;
  logic [66:0] word_o;
  logic        hdr_err;
  logic        block_lock;

  int n_chk = 0;
  int n_bad = 0;
  int nwv = 0;
  int lock_at = -1;
  int errc = 0;

  always #2 clk = ~clk;

  shdr_block_sync dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .in_valid(in_valid),
    .in_bit(in_bit), .word_valid(word_valid), .word_o(word_o),
    .hdr_err(hdr_err), .block_lock(block_lock)
  );

  task automatic check(input string tag, input logic [66:0] act, input logic [66:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mix(input int idx);
    logic [63:0] x;
    x = 64'h9E3779B97F4A7C15 * 64'(idx + 1);
    x = x ^ (x >> 29);
    x = x * 64'hBF58476D1CE4E5B9;
    x = x ^ (x >> 31);
    return x;
  endfunction

  function automatic logic [1:0] good_hdr(input int idx);
    return idx[0] ? 2'b10 : 2'b01;
  endfunction

  // Block as the bench expects it on word_o (R10 layout).
  function automatic logic [66:0] mkblk(input int idx, input bit m67, input logic [1:0] hdr);
    logic [63:0] p;
    p = mix(idx);
    if (m67) return {hdr, ~p[5], p};
    else     return {1'b0, hdr, p};
  endfunction

  task automatic send_bit(input logic b);
    in_valid = 1'b1;
    in_bit   = b;
    @(negedge clk);
    if (word_valid) begin
      nwv++;
      if (block_lock && lock_at < 0) lock_at = nwv;
      if (hdr_err) errc++;
    end
  endtask

  task automatic send_raw(input logic [66:0] w, input bit m67);
    int len;
    len = m67 ? 67 : 66;
    for (int i = len - 1; i >= 0; i--) send_bit(w[i]);
  endtask

  // Sends one block and checks the word seen right after its last bit.
  task automatic send_chk(input int idx, input bit m67, input logic [1:0] hdr,
                          input logic exp_lock, input logic exp_err, input string tag);
    logic [66:0] w;
    w = mkblk(idx, m67, hdr);
    send_raw(w, m67);
    check({tag, " word_valid"}, 67'(word_valid), 67'(1));
    check({tag, " word"}, word_o, w);
    check({tag, " lock"}, 67'(block_lock), 67'(exp_lock));
    check({tag, " hdr_err"}, 67'(hdr_err), 67'(exp_err));
  endtask

  task automatic do_reset(input bit m67);
    in_valid = 1'b0;
    mode_i   = m67;
    rst_n    = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    nwv = 0; lock_at = -1; errc = 0;
  endtask

  // Aligned stream: lock must rise exactly on the 64th good header.
  task automatic lock_aligned(input bit m67, input string tag);
    for (int i = 0; i < 64; i++) begin
      send_chk(i, m67, good_hdr(i), (i == 63), 1'b0, tag);
    end
  endtask

  task automatic t_reset_state();
    do_reset(1'b0);
    check("R8 reset lock", 67'(block_lock), 67'(0));
    check("R8 reset word_valid", 67'(word_valid), 67'(0));
    check("R5 reset hdr_err", 67'(hdr_err), 67'(0));
  endtask

  task automatic t_exact_lock();
    do_reset(1'b0);
    lock_aligned(1'b0, "R1 R4 R10 66-bit");
    do_reset(1'b1);
    lock_aligned(1'b1, "R1 R4 R10 67-bit");
  endtask

  // One leading junk bit equal to the header's first bit: one slip aligns it.
  task automatic t_single_slip();
    logic [66:0] w0;
    do_reset(1'b1);
    w0 = mkblk(0, 1'b1, good_hdr(0));
    send_bit(w0[66]);
    for (int i = 0; i < 65; i++) send_raw(mkblk(i, 1'b1, good_hdr(i)), 1'b1);
    check("R2 R9 lock after one slip at word", 67'(lock_at), 67'(65));
    check("R2 word count", 67'(nwv), 67'(65));
    check("R2 last word aligned", word_o, mkblk(64, 1'b1, good_hdr(64)));
    check("R5 no error while hunting", 67'(errc), 67'(0));
  endtask

  // A bad header one short of lock clears the count.
  task automatic t_count_clear();
    do_reset(1'b0);
    for (int i = 0; i < 63; i++) begin
      if (i == 62) send_chk(i, 1'b0, 2'b11, 1'b0, 1'b0, "R4 bad at 63rd");
      else         send_raw(mkblk(i, 1'b0, good_hdr(i)), 1'b0);
    end
    send_bit(1'b1);
    for (int i = 63; i < 126; i++) send_raw(mkblk(i, 1'b0, good_hdr(i)), 1'b0);
    check("R4 not locked after 63 fresh good", 67'(block_lock), 67'(0));
    send_chk(126, 1'b0, good_hdr(126), 1'b1, 1'b0, "R4 R2 lock at 64th fresh");
    check("R4 lock word index", 67'(lock_at), 67'(127));
  endtask

  task automatic t_window();
    do_reset(1'b0);
    lock_aligned(1'b0, "R4 prelock");
    for (int i = 0; i < 15; i++) send_chk(100 + i, 1'b0, 2'b00, 1'b1, 1'b1, "R5 R6 bad locked");
    for (int i = 15; i < 64; i++) send_chk(100 + i, 1'b0, good_hdr(i), 1'b1, 1'b0, "R7 good fill");
    for (int i = 0; i < 15; i++) send_chk(200 + i, 1'b0, 2'b11, 1'b1, 1'b1, "R7 new window");
    send_chk(215, 1'b0, 2'b00, 1'b0, 1'b1, "R6 16th bad drops lock");
    errc = 0;
    for (int i = 0; i < 3; i++) send_raw(mkblk(300 + i, 1'b0, 2'b00), 1'b0);
    check("R5 no error pulse after loss", 67'(errc), 67'(0));
    check("R6 still unlocked", 67'(block_lock), 67'(0));
  endtask

  task automatic t_mode_change();
    do_reset(1'b0);
    lock_aligned(1'b0, "R8 prelock");
    in_valid = 1'b0;
    mode_i   = 1'b1;
    @(negedge clk);
    check("R8 mode change clears lock", 67'(block_lock), 67'(0));
    @(negedge clk);
    lock_aligned(1'b1, "R8 R1 relock after mode change");
  endtask

  task automatic t_reset_mid();
    do_reset(1'b1);
    lock_aligned(1'b1, "R8 prelock");
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 reset clears lock", 67'(block_lock), 67'(0));
    check("R8 reset clears strobe", 67'(word_valid), 67'(0));
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_offset(input bit m67, input int k, input string tag);
    int matched, wrong, prev, j;
    logic [66:0] w;
    int len;
    len = m67 ? 67 : 66;
    matched = 0; wrong = 0; prev = -1;
    do_reset(m67);
    for (int p = 0; p < k; p++) send_bit(1'($urandom));
    for (int b = 0; b < 260; b++) begin
      w = mkblk(b, m67, good_hdr(b));
      for (int i = len - 1; i >= 0; i--) begin
        send_bit(w[i]);
        if (word_valid && block_lock) begin
          j = -1;
          for (int s = 0; s <= b; s++) begin
            if (mkblk(s, m67, good_hdr(s)) == word_o) j = s;
          end
          if (j >= 0 && (prev < 0 || j == prev + 1)) matched++;
          else wrong++;
          prev = j;
        end
      end
    end
    check({tag, " R2 lock reached"}, 67'(block_lock), 67'(1));
    check({tag, " R2 R10 misaligned locked words"}, 67'(wrong), 67'(0));
    check({tag, " R2 enough locked words"}, 67'(matched >= 20), 67'(1));
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset_state();
    t_exact_lock();
    t_single_slip();
    t_count_clear();
    t_window();
    t_mode_change();
    t_reset_mid();
    t_offset(1'b0, 5, "66 off5");
    t_offset(1'b0, 23, "66 off23");
    t_offset(1'b1, 40, "67 off40");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule